// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit steers a multi-word block move between a set of registers and word-addressed memory. One start pulse hands it a base address, a 16-bit mask of the registers taking part, a walk mode and a load/store select. It then visits the selected registers one at a time. For each one it presents a byte address, the register number and a memory request. Each request is held until memory accepts it. When the last word is accepted it pulses done and offers the updated base value for writeback.

The walk mode can be given directly, as a direction (up or down) and a phase (adjust before or after each word). It can also be given as a stack style. In that case the push or pop direction comes from the load/store select: a store is a push and a load is a pop. The sequencer computes the lowest address of the window once and then counts upward from it. The lowest-numbered register therefore always pairs with the lowest address.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset, and after every finished operation, busy, mem_req, done and wb_we are all low.
- R2: With mode 2'b00 (up, adjust after), stack_sel low and N selected registers, the addresses run from base to base+4N-4 and wb_value is base+4N. For example, three registers at base 0x80010 use 0x80010, 0x80014 and 0x80018, and writeback is 0x8001C.
- R3: With mode 2'b01 (up, adjust before), the addresses run from base+4 to base+4N and wb_value is base+4N.
- R4: With mode 2'b10 (down, adjust after), the addresses run from base-4N+4 to base and wb_value is base-4N.
- R5: With mode 2'b11 (down, adjust before), the addresses run from base-4N to base-4 and wb_value is base-4N.
- R6: Selected registers are issued in ascending index order. Consecutive accepted words are 4 bytes apart, so the lowest index sits at the lowest address.
- R7: With stack_sel high, mode[1] means the stack grows upward and mode[0] means the pointer marks the next free slot. A store pushes and a load pops. The mapping is:
  - full-down: push = 2'b11, pop = 2'b00
  - empty-down: push = 2'b10, pop = 2'b01
  - full-up: push = 2'b01, pop = 2'b10
  - empty-up: push = 2'b00, pop = 2'b11

  For example, a full-down push of two registers with pointer 0x80014 gives wb_value 0x8000C.
- R8: A request holds its address and register index until mem_ready is high at a clock edge. When every word waits t cycles, done is high in cycle 2+N·t, counting the cycle after the start edge as cycle 1.
- R9: An empty mask produces no memory request. done is high in cycle 2, and wb_value equals the base.
- R10: wb_we is high during done exactly when the captured wb_en was high. A start pulse while busy is ignored.
- R11: mem_we is high on every request of a store and low on every request of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| base_addr | input | 32 | Base byte address or stack pointer |
| reg_mask | input | 16 | One bit per register to transfer |
| mode | input | 2 | Walk mode, or stack style when stack_sel is high |
| stack_sel | input | 1 | Interpret mode as a stack style |
| is_load | input | 1 | 1 = memory to registers (pop), 0 = registers to memory (push) |
| wb_en | input | 1 | Request base writeback at the end |
| mem_ready | input | 1 | Memory accepts the current word |
| busy | output | 1 | Operation in progress, including the done cycle |
| mem_req | output | 1 | Word request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the current word |
| reg_idx | output | 4 | Register number paired with the current word |
| done | output | 1 | One-cycle completion pulse |
| wb_we | output | 1 | Write wb_value into the base register |
| wb_value | output | 32 | Updated base value |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the operation:
- requests appear only while busy;
- a stalled request keeps its address and index;
- accepted words step by exactly 4 bytes at strictly rising register numbers;
- done is a single-cycle pulse.

The bench scenarios are needed for everything that depends on the operation itself. That covers the absolute window for each of the four walks and the eight stack cases, the writeback values, the empty-mask path, the 2+N·t latency under wait states, and the fact that a second start during an operation changes nothing.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } lsm_state_e;

  // down: addresses walk toward lower values; pre: adjust before each word
  typedef struct packed {
    logic down;
    logic pre;
  } walk_t;
endpackage

// File: rtl/lsm_mode_map.sv
module lsm_mode_map
  import lsm_pkg::*;
(
  input  logic       stack_sel,
  input  logic [1:0] mode,
  input  logic       is_load,
  output walk_t      walk
);
  // Stack style: mode[1] = grows upward, mode[0] = pointer names free slot.
  // A push walks against a pop; both flip with the load/store select.
  always_comb begin
    if (stack_sel) begin
      walk.down = mode[1] ^ ~is_load;
      walk.pre  = mode[0] ^ ~is_load;
    end else begin
      walk.down = mode[1];
      walk.pre  = mode[0];
    end
  end
endmodule

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int N     = 16,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] partial [0:N];

  assign partial[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_sum
    assign partial[g+1] = partial[g] + CNT_W'(vec[g]);
  end
  assign count = partial[N];
endmodule

// File: rtl/lsm_first_set.sv
module lsm_first_set #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lsm_window.sv
module lsm_window
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  walk_t             walk,
  output logic [ADDR_W-1:0] low_addr,
  output logic [ADDR_W-1:0] new_base
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] bottom;

  assign span   = ADDR_W'(count) * STEP;
  assign bottom = base - span;

  always_comb begin
    unique case ({walk.down, walk.pre})
      2'b00:   low_addr = base;
      2'b01:   low_addr = base + STEP;
      2'b10:   low_addr = bottom + STEP;
      default: low_addr = bottom;
    endcase
    new_base = walk.down ? bottom : (base + span);
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NREG-1:0]   reg_mask,
  input  logic [1:0]        mode,
  input  logic              stack_sel,
  input  logic              is_load,
  input  logic              wb_en,
  input  logic              mem_ready,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              done,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_value
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  lsm_state_e        state_q, state_d;
  logic [NREG-1:0]   mask_q, mask_d;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] wbv_q;
  walk_t             walk_q, walk_in;
  logic              load_q, wben_q;

  logic              cap_en;
  logic              win_en;
  logic              mask_en;
  logic              addr_en;

  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] low_addr;
  logic [ADDR_W-1:0] new_base;

  lsm_mode_map u_map (
    .stack_sel (stack_sel),
    .mode      (mode),
    .is_load   (is_load),
    .walk      (walk_in)
  );

  lsm_popcount #(.N(NREG), .CNT_W(CNT_W)) u_cnt (
    .vec   (mask_q),
    .count (count)
  );

  lsm_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_win (
    .base     (base_q),
    .count    (count),
    .walk     (walk_q),
    .low_addr (low_addr),
    .new_base (new_base)
  );

  lsm_first_set #(.N(NREG), .IDX_W(IDX_W)) u_pick (
    .vec (mask_q),
    .idx (reg_idx)
  );

  // Next-state and enables
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    addr_d  = addr_q;
    cap_en  = 1'b0;
    win_en  = 1'b0;
    mask_en = 1'b0;
    addr_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          mask_en = 1'b1;
          mask_d  = reg_mask;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        win_en  = 1'b1;
        addr_en = 1'b1;
        addr_d  = low_addr;
        state_d = (mask_q == '0) ? ST_DONE : ST_XFER;
      end
      ST_XFER: begin
        if (mem_ready) begin
          mask_en = 1'b1;
          addr_en = 1'b1;
          mask_d  = mask_q & (mask_q - NREG'(1));
          addr_d  = addr_q + STEP;
          if ((mask_q & (mask_q - NREG'(1))) == '0) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      walk_q <= '0;
      load_q <= 1'b0;
      wben_q <= 1'b0;
    end else if (cap_en) begin
      base_q <= base_addr;
      walk_q <= walk_in;
      load_q <= is_load;
      wben_q <= wb_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wbv_q <= '0;
    else if (win_en) wbv_q <= new_base;
  end

  assign busy     = (state_q != ST_IDLE);
  assign mem_req  = (state_q == ST_XFER);
  assign mem_we   = mem_req & ~load_q;
  assign mem_addr = addr_q;
  assign done     = (state_q == ST_DONE);
  assign wb_we    = done & wben_q;
  assign wb_value = wbv_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              done,
  input logic              wb_we
);
  // R1: outside an operation nothing is driven
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done && !wb_we));

  // R6: accepted words step by four bytes at rising register numbers
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(4))));

  p_idx_rising_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (reg_idx > $past(reg_idx))));

  // R8: a stalled request keeps address and index
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(reg_idx)));

  // R10: completion is a single pulse and writeback only during it
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wb_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> done);

  // R11: direction does not change within an operation
  p_we_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (mem_we == $past(mem_we))));
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .reg_idx   (reg_idx),
  .done      (done),
  .wb_we     (wb_we)
);

// File: tb/lsm_addr_seq_bench.sv
`timescale 1ns/1ps
module lsm_addr_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] base_addr;
  logic [15:0] reg_mask;
  logic [1:0]  mode;
  logic        stack_sel;
  logic        is_load;
  logic        wb_en;
  logic        mem_ready;
  logic        busy, mem_req, mem_we, done, wb_we;
  logic [31:0] mem_addr, wb_value;
  logic [3:0]  reg_idx;

  int checks = 0;
  int fails  = 0;
  int lat    = 1;
  int wcnt   = 0;
  int nlog   = 0;
  logic [31:0] log_addr [0:15];
  logic [3:0]  log_idx  [0:15];
  logic        log_we   [0:15];

  lsm_addr_seq u_lsm_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_mask(reg_mask), .mode(mode), .stack_sel(stack_sel), .is_load(is_load),
    .wb_en(wb_en), .mem_ready(mem_ready), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .reg_idx(reg_idx), .done(done),
    .wb_we(wb_we), .wb_value(wb_value)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory model: accepts each word on its lat-th cycle and logs it
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == lat - 1) begin
        mem_ready = 1'b1;
        wcnt = 0;
        if (nlog < 16) begin
          log_addr[nlog] = mem_addr;
          log_idx[nlog]  = reg_idx;
          log_we[nlog]   = mem_we;
        end
        nlog++;
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_walk(input bit st, input logic [1:0] md, input bit ld);
    if (!st) return md;
    case ({md, ld})
      3'b000: return 2'b11;  // full-down push
      3'b001: return 2'b00;  // full-down pop
      3'b010: return 2'b10;  // empty-down push
      3'b011: return 2'b01;  // empty-down pop
      3'b100: return 2'b01;  // full-up push
      3'b101: return 2'b10;  // full-up pop
      3'b110: return 2'b00;  // empty-up push
      default: return 2'b11; // empty-up pop
    endcase
  endfunction

  function automatic logic [31:0] exp_low(input logic [31:0] b, input int n, input logic [1:0] w);
    case (w)
      2'b00: return b;
      2'b01: return b + 32'd4;
      2'b10: return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input int n, input logic [1:0] w);
    return w[1] ? (b - 32'(4 * n)) : (b + 32'(4 * n));
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                        input bit st, input bit ld, input bit wb, input int t,
                        input string tag, input bit poke);
    int n;
    int cyc;
    int k;
    logic [1:0] w;
    n = $countones(m);
    w = exp_walk(st, md, ld);
    lat = t;
    nlog = 0;
    @(negedge clk);
    base_addr = b; reg_mask = m; mode = md; stack_sel = st; is_load = ld; wb_en = wb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (poke) begin
      // second start while busy, with different operands: must be ignored (R10)
      base_addr = b ^ 32'h0000_1000; reg_mask = ~m; mode = ~md; is_load = ~ld; wb_en = ~wb;
      start = 1'b1;
    end
    while (!done && cyc < 500) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(cyc < 500, "R8 watchdog", 32'(cyc), 32'd0);
    chk(cyc == 2 + n * t, (n == 0) ? "R9 latency" : "R8 latency", 32'(cyc), 32'(2 + n * t));
    chk(wb_value == exp_wb(b, n, w), tag, wb_value, exp_wb(b, n, w));
    chk(wb_we == wb, "R10 wb_we", 32'(wb_we), 32'(wb));
    chk(nlog == n, (n == 0) ? "R9 word count" : "R6 word count", 32'(nlog), 32'(n));
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i] && k < nlog && k < 16) begin
        chk(log_idx[k] == 4'(i), "R6 order", 32'(log_idx[k]), 32'(i));
        chk(log_addr[k] == exp_low(b, n, w) + 32'(4 * k), tag, log_addr[k], exp_low(b, n, w) + 32'(4 * k));
        chk(log_we[k] == !ld, "R11 direction", 32'(log_we[k]), 32'(!ld));
        k++;
      end
    end
    @(negedge clk);
    chk(!busy && !done && !mem_req && !wb_we, "R1 idle after", {28'd0, busy, done, mem_req, wb_we}, 32'd0);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    rst_n = 1'b0; start = 1'b0; base_addr = '0; reg_mask = '0; mode = '0;
    stack_sel = 1'b0; is_load = 1'b0; wb_en = 1'b0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !wb_we, "R1 reset", {28'd0, busy, mem_req, done, wb_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'h0008_0010, 16'h000E, 2'b00, 1'b0, 1'b1, 1'b1, 1, "R2 window", 1'b0);
    run_op(32'h0008_0010, 16'h000E, 2'b01, 1'b0, 1'b1, 1'b1, 1, "R3 window", 1'b0);
    run_op(32'h0008_001C, 16'h000E, 2'b10, 1'b0, 1'b1, 1'b1, 2, "R4 window", 1'b0);
    run_op(32'h0008_0014, 16'h000E, 2'b11, 1'b0, 1'b0, 1'b1, 1, "R5 window", 1'b0);
    run_op(32'h0008_0014, 16'h0012, 2'b00, 1'b1, 1'b0, 1'b1, 1, "R7 full-down push", 1'b0);
    chk(wb_value == 32'h0008_000C, "R7 sp", wb_value, 32'h0008_000C);
    for (int s = 0; s < 8; s++)
      run_op(32'h0000_9000, 16'h0C05, 2'(s >> 1), 1'b1, s[0], 1'b1, 1, "R7 stack", 1'b0);
    run_op(32'h0000_4000, 16'h0000, 2'b11, 1'b0, 1'b1, 1'b1, 2, "R9 empty", 1'b0);
    chk(wb_value == 32'h0000_4000, "R9 base kept", wb_value, 32'h0000_4000);
    run_op(32'h0001_0000, 16'h8421, 2'b01, 1'b0, 1'b0, 1'b1, 3, "R8 waits", 1'b0);
    run_op(32'h0002_0000, 16'h00F0, 2'b10, 1'b0, 1'b1, 1'b0, 1, "R10 poke", 1'b1);
    run_op(32'h0003_0000, 16'hFFFF, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R11 full", 1'b0);
    run_op(32'h0000_0008, 16'h8001, 2'b11, 1'b0, 1'b1, 1'b1, 1, "R5 wrap", 1'b0);

    for (int r = 0; r < 40; r++) begin
      logic [15:0] rm;
      logic [1:0]  rmd;
      bit rst_sel, rld, rwb, rpk;
      logic [31:0] rb;
      rm = 16'($urandom);
      if (r % 7 == 0) rm = '0;
      rmd = 2'($urandom);
      rst_sel = bit'($urandom);
      rld = bit'($urandom);
      rwb = bit'($urandom);
      rpk = bit'($urandom);
      rb = $urandom & 32'hFFFF_FFFC;
      case (exp_walk(rst_sel, rmd, rld))
        2'b00:   run_op(rb, rm, rmd, rst_sel, rld, rwb, 1 + ($urandom % 3), "R2 random", rpk);
        2'b01:   run_op(rb, rm, rmd, rst_sel, rld, rwb, 1 + ($urandom % 3), "R3 random", rpk);
        2'b10:   run_op(rb, rm, rmd, rst_sel, rld, rwb, 1 + ($urandom % 3), "R4 random", rpk);
        default: run_op(rb, rm, rmd, rst_sel, rld, rwb, 1 + ($urandom % 3), "R5 random", rpk);
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule